// File: doc/BRIEF.md
# Multi-Mode Timer Channel Start Controller

One 16-bit timer channel that owns a data register and a counter register and decides, per operating mode, what a software start request does, when the counter is first loaded, which pulse advances it, and in which direction. Five modes are supported: interval (periodic down-count with reload), event counting (down-count of external events), capture (free up-count, snapshot into the data register), single-shot (armed down-count started by a hardware trigger) and single-shot capture (armed up-count measurement ended by a trigger).

The surrounding logic supplies a one-cycle count-clock enable pulse from a prescaler, an already-edge-detected external event pulse and a trigger pulse. The channel answers with its counter value, its data register, an enable flag and a one-cycle interrupt pulse. A start request in interval, capture or single-shot modes is remembered and applied on the next count-clock pulse rather than immediately, so the first period is always aligned to the prescaler.

Top module: `tmr_chan_start`

## Requirements
- R1: After synchronous reset the counter, the data register, the enable flag and the interrupt output are all zero.
- R2: A start strobe without a stop strobe sets the enable flag on the next cycle; in the two single-shot modes it is acted on only while the channel is disabled.
- R3: In interval mode (mode code 0, and codes 5 to 7 which behave the same) the counter keeps its old value after a start until the next count-clock pulse, which copies the data register into it.
- R4: In interval mode, once loaded, each count-clock pulse decrements the counter; a pulse that finds the counter at 0x0000 raises the interrupt for one cycle and reloads the data register value.
- R5: In event mode (code 1) a start copies the data register into the counter on the next cycle; later external event pulses decrement it (reload and interrupt at 0x0000 as in R4); count-clock pulses and trigger pulses do not change it.
- R6: In capture mode (code 2) the first count-clock pulse after a start loads 0x0000 and later pulses increment; a trigger pulse copies the counter into the data register and raises the interrupt, and counting continues.
- R7: In single-shot mode (code 3) a start while disabled arms the channel; count-clock pulses do nothing until a trigger, after which the first pulse loads the data register and later pulses decrement; a pulse at 0x0000 raises the interrupt, leaves the counter at 0x0000 and re-arms.
- R8: In single-shot capture mode (code 4) the channel arms as in R7; after a trigger the first count-clock pulse loads 0x0000 and later pulses increment; the next trigger copies the counter into the data register, raises the interrupt and stops counting until a further trigger.
- R9: A stop strobe clears the enable flag and cancels any pending load or armed state; the counter keeps its value and later pulses leave it unchanged.
- R10: A stop strobe in the same cycle as a start strobe wins: the channel ends disabled.
- R11: A data write updates the data register on the next cycle, except that a capture in the same cycle takes precedence.
- R12: Counter, data register, enable flag and interrupt follow a cycle-exact model of R1 to R11 on every clock in all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 3 | Operating mode code (see R3 to R8) |
| sw_start | input | 1 | Software start strobe, one cycle |
| sw_stop | input | 1 | Software stop strobe, one cycle |
| cnt_tick | input | 1 | Count-clock enable pulse from the prescaler |
| ext_event | input | 1 | External event pulse, counted in event mode |
| start_trig | input | 1 | Start trigger in single-shot modes, capture trigger in capture modes |
| data_wr | input | 1 | Data register write enable |
| data_wr_val | input | 16 | Data register write value |
| count_q | output | 16 | Counter register |
| data_q | output | 16 | Data register |
| enable_q | output | 1 | Channel enable flag |
| irq_q | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions take for granted that the mode code does not change while the channel is enabled; a mode switch under a running count has no defined meaning. The stimulus therefore changes the mode only in a cycle after a stop strobe has been taken, and every random segment starts that way, while start, stop, count, event, trigger and write pulses are otherwise free to collide with each other.

// File: rtl/tmr_pkg.sv
// Package: shared types for the timer channel.
// Holds the mode codes, the sequencing state and the operation word passed
// from the start controller to the counter datapath.
package tmr_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_INTERVAL    = 3'd0,
        MD_EVENT       = 3'd1,
        MD_CAPTURE     = 3'd2,
        MD_ONESHOT     = 3'd3,
        MD_CAP_ONESHOT = 3'd4
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PEND = 2'd2,
        ST_RUN  = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic ld_data;
        logic ld_zero;
        logic dec;
        logic inc;
        logic capture;
        logic irq;
    } tmr_op_t;

    // Counts up (capture style) in codes 2 and 4.
    function automatic logic mode_up(input logic [MODE_W-1:0] m);
        return (m == MD_CAPTURE) || (m == MD_CAP_ONESHOT);
    endfunction

    // Needs a hardware trigger to run in codes 3 and 4.
    function automatic logic mode_oneshot(input logic [MODE_W-1:0] m);
        return (m == MD_ONESHOT) || (m == MD_CAP_ONESHOT);
    endfunction

    function automatic logic mode_event(input logic [MODE_W-1:0] m);
        return m == MD_EVENT;
    endfunction

endpackage

// File: rtl/tmr_start_ctl.sv
// Start controller: owns the enable flag and the sequencing state
// (idle, armed for trigger, load pending, running) and turns the strobes and
// pulses of one cycle into a single operation word for the datapath.
// Assumes mode_sel is held steady while the channel is enabled.
module tmr_start_ctl
    import tmr_pkg::*;
#(
    parameter int unsigned MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode_sel,
    input  logic          sw_start,
    input  logic          sw_stop,
    input  logic          cnt_tick,
    input  logic          ext_event,
    input  logic          start_trig,
    input  logic          cnt_zero,
    output logic          en_q,
    output tmr_op_t       op
);

    tmr_state_e st_q, st_n;
    logic       en_n;
    logic       is_up, is_one, is_evt, tick_src;

    // Mode classification used by every decision below.
    always_comb begin
        is_up    = mode_up(mode_sel);
        is_one   = mode_oneshot(mode_sel);
        is_evt   = mode_event(mode_sel);
        tick_src = is_evt ? ext_event : cnt_tick;
    end

    // Next state, next enable and datapath operation for this cycle.
    always_comb begin
        st_n = st_q;
        en_n = en_q;
        op   = '0;
        if (sw_stop) begin
            en_n = 1'b0;
            st_n = ST_IDLE;
        end else if (sw_start && !(is_one && en_q)) begin
            en_n = 1'b1;
            if (is_evt) begin
                op.ld_data = 1'b1;
                st_n       = ST_RUN;
            end else if (is_one) begin
                st_n = ST_WAIT;
            end else begin
                st_n = ST_PEND;
            end
        end else begin
            unique case (st_q)
                ST_WAIT: if (start_trig) st_n = ST_PEND;
                ST_PEND: begin
                    if (cnt_tick) begin
                        op.ld_zero = is_up;
                        op.ld_data = !is_up;
                        st_n       = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (is_up) begin
                        if (start_trig) begin
                            op.capture = 1'b1;
                            op.irq     = 1'b1;
                            if (is_one) st_n = ST_WAIT;
                            else        op.inc = cnt_tick;
                        end else begin
                            op.inc = cnt_tick;
                        end
                    end else if (tick_src) begin
                        if (cnt_zero) begin
                            op.irq = 1'b1;
                            if (is_one) st_n = ST_WAIT;
                            else        op.ld_data = 1'b1;
                        end else begin
                            op.dec = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            en_q <= 1'b0;
        end else begin
            st_q <= st_n;
            en_q <= en_n;
        end
    end

    // R2: a start without stop enables the channel.
    a_r2_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && !sw_stop) |=> en_q);

    // R9: stop clears the enable and returns to idle.
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> (!en_q && st_q == ST_IDLE));

    // R7: an armed channel stays armed until a trigger or stop arrives.
    a_r7_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !start_trig && !sw_stop) |=> st_q == ST_WAIT);

    // R12: input assumption, mode is steady while enabled.
    a_r12_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> $stable(mode_sel));

endmodule

// File: rtl/tmr_count_core.sv
// Counter datapath: applies the operation word to the counter and data
// registers and registers the interrupt pulse. Assumes at most one counter
// operation is set in a cycle (guaranteed by the start controller).
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_op_t      op,
    input  logic         data_wr,
    input  logic [W-1:0] data_wr_val,
    output logic [W-1:0] count_q,
    output logic [W-1:0] data_q,
    output logic         irq_q,
    output logic         cnt_zero
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign cnt_zero = (count_q == '0);

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (op.ld_data) count_q <= data_q;
        else if (op.ld_zero) count_q <= '0;
        else if (op.dec)     count_q <= count_q - ONE;
        else if (op.inc)     count_q <= count_q + ONE;
    end

    // Data register: capture has precedence over a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          data_q <= '0;
        else if (op.capture) data_q <= count_q;
        else if (data_wr)    data_q <= data_wr_val;
    end

    // Interrupt pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= op.irq;
    end

    // R6: a capture moves the counter value into the data register.
    a_r6_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
        op.capture |=> data_q == $past(count_q));

endmodule

// File: rtl/tmr_chan_start.sv
// Top: one timer channel with mode-dependent start handling. Connects the
// start controller to the counter datapath. Assumes pulses on cnt_tick,
// ext_event and start_trig are already synchronous one-cycle strobes.
module tmr_chan_start
    import tmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              cnt_tick,
    input  logic              ext_event,
    input  logic              start_trig,
    input  logic              data_wr,
    input  logic [W-1:0]      data_wr_val,
    output logic [W-1:0]      count_q,
    output logic [W-1:0]      data_q,
    output logic              enable_q,
    output logic              irq_q
);

    tmr_op_t op;
    logic    cnt_zero;

    tmr_start_ctl #(.MW(MODE_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .sw_start   (sw_start),
        .sw_stop    (sw_stop),
        .cnt_tick   (cnt_tick),
        .ext_event  (ext_event),
        .start_trig (start_trig),
        .cnt_zero   (cnt_zero),
        .en_q       (enable_q),
        .op         (op)
    );

    tmr_count_core #(.W(W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .data_wr     (data_wr),
        .data_wr_val (data_wr_val),
        .count_q     (count_q),
        .data_q      (data_q),
        .irq_q       (irq_q),
        .cnt_zero    (cnt_zero)
    );

    // R9: the counter is frozen by a stop.
    a_r9_stop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> count_q == $past(count_q));

    // R5: in event mode a start loads the data register at once.
    a_r5_event_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && !sw_stop && mode_sel == MD_EVENT) |=> count_q == $past(data_q));

endmodule

// File: tb/tmr_chan_start_tb_top.sv
module tmr_chan_start_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        sw_start = 1'b0, sw_stop = 1'b0, cnt_tick = 1'b0;
    logic        ext_event = 1'b0, start_trig = 1'b0, data_wr = 1'b0;
    logic [15:0] data_wr_val = 16'h0;
    logic [15:0] count_q, data_q;
    logic        enable_q, irq_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    tmr_chan_start dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_start(sw_start),
        .sw_stop(sw_stop), .cnt_tick(cnt_tick), .ext_event(ext_event),
        .start_trig(start_trig), .data_wr(data_wr), .data_wr_val(data_wr_val),
        .count_q(count_q), .data_q(data_q), .enable_q(enable_q), .irq_q(irq_q)
    );

    // Behavioural reference: phase 0 idle, 1 armed, 2 waiting first tick, 3 running.
    logic [15:0] m_cnt, m_dat, n_cnt, n_dat;
    bit          m_en, m_irq, n_en, n_irq, up, one, evm, cap;
    int          m_ph, n_ph;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dat = 0; m_en = 0; m_irq = 0; m_ph = 0;
        end else begin
            n_cnt = m_cnt; n_dat = m_dat; n_en = m_en; n_irq = 0; n_ph = m_ph; cap = 0;
            up  = (mode_sel == 2) || (mode_sel == 4);
            one = (mode_sel == 3) || (mode_sel == 4);
            evm = (mode_sel == 1);
            if (sw_stop) begin
                n_en = 0; n_ph = 0;
            end else if (sw_start && !(one && m_en)) begin
                n_en = 1;
                if (evm) begin n_cnt = m_dat; n_ph = 3; end
                else n_ph = one ? 1 : 2;
            end else if (m_ph == 1) begin
                if (start_trig) n_ph = 2;
            end else if (m_ph == 2) begin
                if (cnt_tick) begin n_cnt = up ? 16'h0 : m_dat; n_ph = 3; end
            end else if (m_ph == 3) begin
                if (up) begin
                    if (start_trig) begin
                        cap = 1; n_irq = 1;
                        if (one) n_ph = 1;
                        else if (cnt_tick) n_cnt = m_cnt + 1;
                    end else if (cnt_tick) n_cnt = m_cnt + 1;
                end else if (evm ? ext_event : cnt_tick) begin
                    if (m_cnt == 0) begin
                        n_irq = 1;
                        if (one) n_ph = 1; else n_cnt = m_dat;
                    end else n_cnt = m_cnt - 1;
                end
            end
            if (cap) n_dat = m_cnt;
            else if (data_wr) n_dat = data_wr_val;
            m_cnt = n_cnt; m_dat = n_dat; m_en = n_en; m_irq = n_irq; m_ph = n_ph;
        end
    end

    // R12: compare all outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (count_q !== m_cnt || data_q !== m_dat || enable_q !== m_en || irq_q !== m_irq) begin
                bad++;
                $display("FAIL R12 model: got cnt=%h dat=%h en=%b irq=%b exp cnt=%h dat=%h en=%b irq=%b",
                         count_q, data_q, enable_q, irq_q, m_cnt, m_dat, m_en, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, changed 5 ns after a rising edge.
    task automatic drv(input logic [2:0] md, input logic st, input logic sp,
                       input logic tk, input logic ev, input logic tg,
                       input logic wr, input logic [15:0] wv);
        @(posedge clk); #5;
        mode_sel = md; sw_start = st; sw_stop = sp; cnt_tick = tk;
        ext_event = ev; start_trig = tg; data_wr = wr; data_wr_val = wv;
    endtask

    task automatic idle(input logic [2:0] md);
        drv(md, 0, 0, 0, 0, 0, 0, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        idle(0);
        chk("R1 count", count_q, 0); chk("R1 data", data_q, 0);
        chk("R1 enable", {15'h0, enable_q}, 0); chk("R1 irq", {15'h0, irq_q}, 0);

        // Interval mode
        drv(0, 0, 0, 0, 0, 0, 1, 16'd3);
        drv(0, 1, 0, 0, 0, 0, 0, 0); idle(0);
        chk("R2 enable", {15'h0, enable_q}, 1);
        chk("R3 held before tick", count_q, 0);
        drv(0, 0, 0, 1, 0, 0, 0, 0); idle(0);
        chk("R3 first tick loads", count_q, 3);
        for (int i = 0; i < 3; i++) drv(0, 0, 0, 1, 0, 0, 0, 0);
        idle(0); chk("R4 decrement", count_q, 0);
        drv(0, 0, 0, 1, 0, 0, 0, 0); idle(0);
        chk("R4 irq", {15'h0, irq_q}, 1); chk("R4 reload", count_q, 3);
        idle(0); chk("R4 irq one cycle", {15'h0, irq_q}, 0);
        drv(0, 0, 1, 0, 0, 0, 0, 0); idle(0);
        chk("R9 disabled", {15'h0, enable_q}, 0); chk("R9 count kept", count_q, 3);
        drv(0, 0, 0, 1, 0, 0, 0, 0); idle(0);
        chk("R9 tick ignored", count_q, 3);

        // Event mode
        drv(1, 0, 0, 0, 0, 0, 1, 16'd5);
        drv(1, 1, 0, 0, 0, 0, 0, 0); idle(1);
        chk("R5 start loads", count_q, 5);
        drv(1, 0, 0, 1, 0, 0, 0, 0); idle(1); chk("R5 tick ignored", count_q, 5);
        drv(1, 0, 0, 0, 0, 1, 0, 0); idle(1); chk("R5 trigger ignored", count_q, 5);
        drv(1, 0, 0, 0, 1, 0, 0, 0); idle(1); chk("R5 event decrements", count_q, 4);
        drv(1, 0, 1, 0, 0, 0, 0, 0);

        // Capture mode
        idle(2);
        drv(2, 1, 0, 0, 0, 0, 0, 0); idle(2); chk("R6 held before tick", count_q, 4);
        drv(2, 0, 0, 1, 0, 0, 0, 0); idle(2); chk("R6 loads zero", count_q, 0);
        drv(2, 0, 0, 1, 0, 0, 0, 0); drv(2, 0, 0, 1, 0, 0, 0, 0); idle(2);
        chk("R6 increments", count_q, 2);
        drv(2, 0, 0, 0, 0, 1, 0, 0); idle(2);
        chk("R6 capture data", data_q, 2); chk("R6 capture irq", {15'h0, irq_q}, 1);
        drv(2, 0, 0, 0, 0, 1, 1, 16'h0055); idle(2);
        chk("R11 capture beats write", data_q, 2);
        drv(2, 0, 0, 0, 0, 0, 1, 16'hAAAA); idle(2);
        chk("R11 write", data_q, 16'hAAAA);
        drv(2, 0, 1, 0, 0, 0, 0, 0);

        // Single-shot mode
        drv(3, 0, 0, 0, 0, 0, 1, 16'd7);
        drv(3, 1, 0, 0, 0, 0, 0, 0);
        drv(3, 0, 0, 1, 0, 0, 0, 0); idle(3);
        chk("R7 armed no load", count_q, 2);
        drv(3, 0, 0, 0, 0, 1, 0, 0);
        drv(3, 0, 0, 1, 0, 0, 0, 0); idle(3); chk("R7 loads data", count_q, 7);
        for (int i = 0; i < 7; i++) drv(3, 0, 0, 1, 0, 0, 0, 0);
        idle(3); chk("R7 counted down", count_q, 0);
        drv(3, 0, 0, 1, 0, 0, 0, 0); idle(3);
        chk("R7 irq", {15'h0, irq_q}, 1); chk("R7 stays zero", count_q, 0);
        drv(3, 0, 0, 1, 0, 0, 0, 0); idle(3);
        chk("R7 re-armed", count_q, 0); chk("R7 no second irq", {15'h0, irq_q}, 0);
        drv(3, 0, 1, 0, 0, 0, 0, 0);

        // Single-shot capture mode
        drv(4, 0, 0, 0, 0, 0, 1, 16'd9);
        drv(4, 1, 0, 0, 0, 0, 0, 0);
        drv(4, 0, 0, 0, 0, 1, 0, 0);
        drv(4, 0, 0, 1, 0, 0, 0, 0); idle(4); chk("R8 loads zero", count_q, 0);
        drv(4, 0, 0, 1, 0, 0, 0, 0); idle(4); chk("R8 increments", count_q, 1);
        drv(4, 0, 0, 0, 0, 1, 0, 0); idle(4);
        chk("R8 capture", data_q, 1); chk("R8 irq", {15'h0, irq_q}, 1);
        drv(4, 0, 0, 1, 0, 0, 0, 0); idle(4); chk("R8 stopped", count_q, 1);
        drv(4, 0, 1, 0, 0, 0, 0, 0);

        // Stop beats start
        idle(0);
        drv(0, 1, 1, 0, 0, 0, 0, 0); idle(0);
        chk("R10 stop wins", {15'h0, enable_q}, 0);

        // Random segments, mode changed only after a stop
        for (int s = 0; s < 40; s++) begin
            logic [2:0] md;
            md = 3'($urandom_range(0, 7));
            drv(mode_sel, 0, 1, 0, 0, 0, 0, 0);
            drv(md, 0, 0, 0, 0, 0, $urandom_range(0, 1) == 1, 16'($urandom_range(0, 6)));
            drv(md, 1, 0, 0, 0, 0, 0, 0);
            for (int c = 0; c < 50; c++) begin
                drv(md, $urandom_range(0, 19) == 0, $urandom_range(0, 49) == 0,
                    $urandom_range(0, 9) < 4, $urandom_range(0, 9) < 3,
                    $urandom_range(0, 9) == 0, $urandom_range(0, 19) == 0,
                    16'($urandom_range(0, 8)));
            end
        end
        idle(mode_sel); idle(mode_sel);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule